// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex serial port for a host that runs on machine cycles of twelve oscillator clocks. It moves one byte at a time over a single data pin and drives a shift clock for the remote device. Each byte goes out or comes in least significant bit first, one bit per machine cycle. The serial rate is therefore the clock frequency divided by twelve.

A free-running slot counter starts from reset. It counts the twelve slots of a machine cycle, from S1P1 through S6P2 (slot index = 2*(state-1) + (phase-1)). Every pin event is decoded from this counter. A transfer ends when a marker bit reaches a fixed position in a shift register. A transmitted byte carries a trailing 1 marker in a 9-bit register. A received byte starts from a preloaded 0 marker. The transmit side is a valid/ready input. A byte is taken only on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low for the whole of any transfer or pending transfer, which is the only back-pressure. The receive side is a valid/ready output. `rx_valid` (the receive flag) stays high, and `rx_data` stays unchanged, until the host accepts them with `rx_ready`. While `rx_valid` is high no new reception begins. `tx_done` is a plain status flag.

Top module: `syncser_port`

## Requirements
- R1: After reset the port is idle: `tx_ready`=1, `sd_oe`=0, `sclk_o`=1, `tx_done`=0, `rx_valid`=0. The slot counter starts at slot 0 (S1P1) on the first clock after reset and wraps every 12 clocks. `sclk_o` stays high while idle.
- R2: A byte is accepted on a clock edge with `tx_valid`=1 and `tx_ready`=1. `tx_ready` is 1 only while no transfer is active or pending. A `tx_valid` raised during a transfer has no effect on the byte being sent.
- R3: If a write is accepted on the edge that ends a slot of machine cycle c, `sd_oe` is 1 exactly during machine cycles c+2 through c+9.
- R4: During machine cycle c+2+k (k=0..7), `sd_o` carries bit k of the written byte, held for the whole cycle.
- R5: During every active cycle (transmit or receive), `sclk_o` is low in slots 4..9 (S3P1..S5P2) and high in slots 10,11,0..3. Outside active cycles it is high.
- R6: `tx_done` rises at slot 0 of cycle c+10. It stays high until the next accepted write, which clears it.
- R7: A reception starts when `rx_en`=1, `rx_valid`=0 and the port is idle. If that condition is seen on an edge ending a slot of cycle c, shift-clock pulses appear in cycles c+2 through c+9, and `sd_oe` stays 0.
- R8: The data pin is sampled on the edge ending slot 9 (S5P2) of each receive cycle. Pin changes in slots 10 and 11 do not alter the received byte.
- R9: The bit sampled in cycle c+2+k becomes bit k of `rx_data`. `rx_valid` rises at slot 0 of cycle c+10 with the completed byte.
- R10: `rx_valid` falls one edge after `rx_valid`=1 and `rx_ready`=1. While it is high, `rx_data` holds and no reception starts even with `rx_en`=1.
- R11: If a write and a reception start coincide on the same edge, the write wins and the byte is transmitted with R3 timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Host offers a byte to send |
| tx_ready | output | 1 | Port can take a byte (idle) |
| tx_data | input | DW | Byte to send |
| tx_done | output | 1 | Transmit-complete flag |
| rx_en | input | 1 | Receive enable |
| rx_valid | output | 1 | Receive flag, byte available |
| rx_ready | input | 1 | Host accepts the received byte |
| rx_data | output | DW | Received byte |
| sd_i | input | 1 | Data pin input value |
| sd_o | output | 1 | Data pin output value |
| sd_oe | output | 1 | Data pin output enable |
| sclk_o | output | 1 | Shift clock pin |

## Verification
The hardest case to reach is a write or a receive start that lands in every one of the twelve slots of a machine cycle. The two-cycle start latency hinges on whether the accepting edge is the one that ends S6P2. The bench sweeps all 256 byte values in each direction and staggers each start by a delay that cycles through the slots. It also mixes in writes that collide with a receive start and writes offered mid-transfer. During reception it flips the pin in slots 10 and 11, after the sample point, so a byte assembled from the wrong instant is caught.

// File: rtl/syncser_pkg.sv
package syncser_pkg;
  localparam int STATES_PER_CYC   = 6;
  localparam int PHASES_PER_STATE = 2;
  localparam int SLOTS_PER_CYC    = STATES_PER_CYC * PHASES_PER_STATE;
  localparam int SLOT_W           = $clog2(SLOTS_PER_CYC);

  function automatic int slot_of(input int st, input int ph);
    return (st - 1) * PHASES_PER_STATE + (ph - 1);
  endfunction

  localparam int SLOT_SAMPLE  = slot_of(5, 2);
  localparam int SLOT_SHIFT   = slot_of(6, 2);
  localparam int SLOT_LO_FROM = slot_of(3, 1);
  localparam int SLOT_LO_TO   = slot_of(5, 2);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX_WAIT1,
    ST_TX_WAIT2,
    ST_TX,
    ST_RX_WAIT1,
    ST_RX_WAIT2,
    ST_RX
  } port_st_e;
endpackage

// File: rtl/syncser_slotctr.sv
module syncser_slotctr
  import syncser_pkg::*;
#(
  parameter int SLOTS = SLOTS_PER_CYC
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot,
  output logic              wrap
);
  assign wrap = (slot == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    slot <= '0;
    else if (wrap) slot <= '0;
    else           slot <= slot + 1'b1;
  end
endmodule

// File: rtl/syncser_txsr.sv
module syncser_txsr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic [DW-1:0] din,
  output logic          bit_o,
  output logic          near_end
);
  logic [DW:0] sr;

  // marker 1 above the byte; zeros fill from the top on every shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= {1'b1, din};
    else if (shift) sr <= {1'b0, sr[DW:1]};
  end

  assign bit_o    = sr[0];
  assign near_end = sr[1] && (sr[DW:2] == '0);
endmodule

// File: rtl/syncser_rxsr.sv
module syncser_rxsr #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          preload,
  input  logic          shift,
  input  logic          sample_i,
  output logic          marker_top,
  output logic [DW-1:0] word_o
);
  logic [DW-1:0] sr;
  logic [DW-1:0] nxt;

  assign nxt = {sr[DW-2:0], sample_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr <= '1;
    else if (preload) sr <= {{(DW-1){1'b1}}, 1'b0};
    else if (shift)   sr <= nxt;
  end

  assign marker_top = ~sr[DW-1];

  // first sampled bit ends up at the top: reverse for LSB-first order
  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign word_o[i] = nxt[DW-1-i];
  end
endmodule

// File: rtl/syncser_port.sv
module syncser_port
  import syncser_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  output logic          tx_done,
  input  logic          rx_en,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  input  logic          sd_i,
  output logic          sd_o,
  output logic          sd_oe,
  output logic          sclk_o
);
  logic [SLOT_W-1:0] slot;
  logic              cyc_end;
  port_st_e          st;
  logic              tx_fire, rx_start;
  logic              tx_bit, tx_near_end;
  logic              rx_marker;
  logic [DW-1:0]     rx_word;
  logic              pin_smp;
  logic              active, clk_lo_slot;

  syncser_slotctr #(.SLOTS(SLOTS_PER_CYC)) u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .slot  (slot),
    .wrap  (cyc_end)
  );

  assign tx_ready = (st == ST_IDLE);
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_start = rx_en && !rx_valid && (st == ST_IDLE) && !tx_fire;

  syncser_txsr #(.DW(DW)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tx_fire),
    .shift    ((st == ST_TX) && cyc_end),
    .din      (tx_data),
    .bit_o    (tx_bit),
    .near_end (tx_near_end)
  );

  syncser_rxsr #(.DW(DW)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .preload    ((st == ST_RX_WAIT2) && cyc_end),
    .shift      ((st == ST_RX) && cyc_end),
    .sample_i   (pin_smp),
    .marker_top (rx_marker),
    .word_o     (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            pin_smp <= 1'b1;
    else if (slot == SLOT_W'(SLOT_SAMPLE)) pin_smp <= sd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      tx_done  <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (tx_fire) begin
            tx_done <= 1'b0;
            st      <= cyc_end ? ST_TX_WAIT2 : ST_TX_WAIT1;
          end else if (rx_start) begin
            st      <= cyc_end ? ST_RX_WAIT2 : ST_RX_WAIT1;
          end
        end
        ST_TX_WAIT1: if (cyc_end) st <= ST_TX_WAIT2;
        ST_TX_WAIT2: if (cyc_end) st <= ST_TX;
        ST_TX: begin
          if (cyc_end && tx_near_end) begin
            st      <= ST_IDLE;
            tx_done <= 1'b1;
          end
        end
        ST_RX_WAIT1: if (cyc_end) st <= ST_RX_WAIT2;
        ST_RX_WAIT2: if (cyc_end) st <= ST_RX;
        ST_RX: begin
          if (cyc_end && rx_marker) begin
            st       <= ST_IDLE;
            rx_valid <= 1'b1;
            rx_data  <= rx_word;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign active      = (st == ST_TX) || (st == ST_RX);
  assign clk_lo_slot = (slot >= SLOT_W'(SLOT_LO_FROM)) && (slot <= SLOT_W'(SLOT_LO_TO));
  assign sclk_o      = !(active && clk_lo_slot);
  assign sd_oe       = (st == ST_TX);
  assign sd_o        = sd_oe ? tx_bit : 1'b1;
endmodule

// File: rtl/syncser_chk.sv
module syncser_chk
  import syncser_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SLOT_W-1:0] slot,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_done,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DW-1:0]     rx_data,
  input logic              sd_o,
  input logic              sd_oe,
  input logic              sclk_o
);
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> !tx_ready);

  p_oe_starts_s1p1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe) |-> (slot == '0));

  p_bit_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe && slot != '0) |-> $stable(sd_o));

  p_sclk_low_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_o |-> (slot >= SLOT_W'(SLOT_LO_FROM) && slot <= SLOT_W'(SLOT_LO_TO)));

  p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_oe) |-> (tx_done && slot == '0));

  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !(tx_valid && tx_ready)) |=> tx_done);

  p_rx_done_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> (slot == '0 && !sd_oe));

  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind syncser_port syncser_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .slot     (slot),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_done  (tx_done),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_data  (rx_data),
  .sd_o     (sd_o),
  .sd_oe    (sd_oe),
  .sclk_o   (sclk_o)
);

// File: tb/syncser_port_tb.sv
`timescale 1ns/1ps
module syncser_port_tb;
  localparam int DW = 8;
  localparam int SPC = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [DW-1:0] tx_data = '0;
  logic          tx_done;
  logic          rx_en = 1'b0;
  logic          rx_valid;
  logic          rx_ready = 1'b0;
  logic [DW-1:0] rx_data;
  logic          sd_i = 1'b1;
  logic          sd_o, sd_oe, sclk_o;

  int checks = 0;
  int errors = 0;
  int cnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) cnt <= cnt + 1;

  syncser_port #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_done(tx_done),
    .rx_en(rx_en), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe), .sclk_o(sclk_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors <= 20)
        $display("FAIL %s: actual %0d expected %0d (tick %0d)", tag, act, exp, cnt);
    end
  endtask

  function automatic bit sclk_exp(input bit act, input int sl);
    return !(act && sl >= 4 && sl <= 9);
  endfunction

  task automatic tx_byte(input logic [7:0] b, input int dly, input bit intrude, input bit with_rx);
    int c, cyc, sl;
    bit eo;
    repeat (dly) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = b;
    if (with_rx) rx_en = 1'b1;
    c = cnt / SPC;
    do begin
      @(negedge clk);
      cyc = cnt / SPC;
      sl  = cnt % SPC;
      eo  = (cyc >= c + 2) && (cyc <= c + 9);
      chk(sd_oe == eo, with_rx ? "R11 R3 oe" : "R3 oe", sd_oe, eo);
      if (eo) chk(sd_o == b[cyc-c-2], "R4 bit", sd_o, b[cyc-c-2]);
      chk(sclk_o == sclk_exp(eo, sl), "R5 sclk", sclk_o, sclk_exp(eo, sl));
      chk(tx_done == (cyc >= c + 10), "R6 done", tx_done, cyc >= c + 10);
      chk(tx_ready == (cyc >= c + 10), "R2 ready", tx_ready, cyc >= c + 10);
      if (cnt == c * SPC + (cnt - c * SPC) && cyc == c || cyc == c + 1) begin
        if (!(intrude && cyc >= c + 4)) tx_valid = 1'b0;
        rx_en = 1'b0;
      end
      if (intrude && cyc == c + 4 && sl == 3) begin
        tx_valid = 1'b1;
        tx_data  = ~b;
      end
      if (intrude && cyc == c + 5 && sl == 0) tx_valid = 1'b0;
    end while (cnt < (c + 10) * SPC + 1);
    tx_valid = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] b, input int dly);
    int c, cyc, sl;
    bit ea;
    repeat (dly) @(negedge clk);
    rx_en = 1'b1;
    c = cnt / SPC;
    do begin
      @(negedge clk);
      cyc = cnt / SPC;
      sl  = cnt % SPC;
      ea  = (cyc >= c + 2) && (cyc <= c + 9);
      chk(sclk_o == sclk_exp(ea, sl), "R7 R5 sclk", sclk_o, sclk_exp(ea, sl));
      chk(sd_oe == 1'b0, "R7 oe", sd_oe, 0);
      chk(rx_valid == (cyc >= c + 10), "R9 valid", rx_valid, cyc >= c + 10);
      chk(tx_ready == (cyc >= c + 10), "R2 ready", tx_ready, cyc >= c + 10);
      if (ea && sl == 0)  sd_i = b[cyc-c-2];
      if (ea && sl == 10) sd_i = ~b[cyc-c-2];
    end while (cnt < (c + 10) * SPC + 1);
    chk(rx_data == b, "R9 R8 data", rx_data, b);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      sd_i = ~sd_i;
      chk(sclk_o == 1'b1, "R10 no restart", sclk_o, 1);
      chk(rx_valid == 1'b1 && rx_data == b, "R10 hold", rx_data, b);
    end
    rx_en    = 1'b0;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(rx_valid == 1'b0, "R10 accept", rx_valid, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    chk(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
    chk(sd_oe == 1'b0, "R1 oe", sd_oe, 0);
    chk(sclk_o == 1'b1, "R1 sclk", sclk_o, 1);
    chk(tx_done == 1'b0, "R1 done", tx_done, 0);
    chk(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      chk(sclk_o == 1'b1 && sd_oe == 1'b0, "R1 idle", sclk_o, 1);
    end
    for (int b = 0; b < 256; b++)
      tx_byte(8'(b), b % 13, (b % 5) == 0, (b % 17) == 3);
    for (int b = 0; b < 256; b++)
      rx_byte(8'(b), b % 11);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done (tick %0d)", cnt);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule